// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is a sequential linear-phase FIR filter for coefficient sets that are mirror-symmetric about their centre. It keeps a circular history of accepted input samples. For each new sample it walks the history from both ends at once. Each clock it fetches two samples that share a coefficient and adds them in a pre-adder one bit wider than a sample. The sum is multiplied by that coefficient and the product is accumulated. Only one multiplier exists, and the coefficient store holds half the taps. Each output therefore costs ceil(M/2) multiply-accumulate cycles, where M is the tap count.

Software or a neighbouring block first writes the half coefficient set. It then presents one sample at a time with a single-cycle strobe, together with the tap count wanted for that sample. The accumulated sum is rounded to the sample format, saturated and registered. A one-cycle valid pulse marks the result. An odd tap count is handled by using the centre sample once on the last cycle.

Top module: `folded_fir`

## Requirements
- R1: While reset is held and right after it, out_valid is 0 and out_data is 0; all coefficients read as zero, so a sample processed before any coefficient write yields 0.
- R2: For an even tap count M, the result is y = sum over k < M/2 of b_k * (x(n-k) + x(n-(M-1-k))). Samples are signed two's complement (8 bits) and coefficients are signed with 7 fractional bits. The result out_data = (y + 64) >>> 7, an arithmetic shift, which rounds halves upward.
- R3: For an odd tap count M, the last of the (M+1)/2 cycles uses the centre sample x(n-(M-1)/2) once, with coefficient b_((M-1)/2), instead of doubling it.
- R4: The pre-adder keeps the full 9-bit pair sum, so two samples of -128 add to -256. The rounded result is clamped to the range [-128, 127].
- R5: A sample is accepted on a rising edge where in_valid is 1, no computation is in progress and coef_we is 0. out_valid then goes high after the (ceil(M/2)+1)-th following rising edge and stays high for exactly one cycle; out_data changes only when out_valid is high.
- R6: A sample presented while a computation is in progress is dropped: it is not stored in the history and does not change the output being computed.
- R7: tap_num is sampled when a sample is accepted; values below 2 act as 2 and values above 16 act as 16.
- R8: Coefficient address k (0 to 7) holds b_k, which is applied to both sample positions n-k and n-(M-1-k).
- R9: A cycle with coef_we high writes coef_data to coef_addr, clears the whole sample history to zero and abandons any computation in progress without an out_valid pulse.
- R10: The history is a 16-entry circular buffer; results stay correct after any number of accepted samples as the write position wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_we | input | 1 | Coefficient write strobe; also clears the history and aborts |
| coef_addr | input | 3 | Coefficient index k |
| coef_data | input | 8 | Signed coefficient, 7 fractional bits |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Signed input sample |
| tap_num | input | 5 | Tap count M, sampled at acceptance |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 8 | Rounded, saturated filter output |

## Verification
The checker assumes that reset is held low from time zero. It also assumes that in_valid, coef_we and tap_num carry defined values at every rising edge. Apart from that it accepts any input sequence: strobes during a computation, out-of-range tap counts and coefficient writes at any moment. The bench changes every input only at falling clock edges. It raises in_valid for a single cycle per sample, and it injects the disturbing cases on purpose: strobes while busy, coefficient writes mid-computation, and tap counts of 0 and 25. These fall within what the checker accepts.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fold_state_e;
endpackage

// File: rtl/fold_rst_sync.sv
module fold_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fold_hist_ram.sv
// Sample history: one write port, two combinational read ports, bulk clear.
module fold_hist_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic              hit;
    logic [DATA_W-1:0] row_q;
    logic [DATA_W-1:0] row_d;
    logic              row_en;

    assign hit = we && (waddr == AW'(i));

    always_comb begin
      row_en = clr || hit;
      row_d  = clr ? '0 : wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= row_d;
      end
    end

    assign rows[i] = row_q;
  end

  assign rdata_a = rows[raddr_a];
  assign rdata_b = rows[raddr_b];
endmodule

// File: rtl/fold_coef_ram.sv
// Half-depth coefficient store: entry k serves both mirrored taps.
module fold_coef_ram #(
  parameter int COEF_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [COEF_W-1:0] rdata
);
  logic [COEF_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/fold_ctrl.sv
// Sequencer: circular write pointer, mirrored read addresses, pair counter.
module fold_ctrl
  import fir_fold_pkg::*;
#(
  parameter int MAX_TAPS  = 16,
  localparam int AW       = $clog2(MAX_TAPS),
  localparam int HALF     = MAX_TAPS / 2,
  localparam int HALF_AW  = $clog2(HALF),
  localparam int TAP_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               in_valid,
  input  logic [TAP_W-1:0]   tap_num,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [AW-1:0]      rd_addr_a,
  output logic [AW-1:0]      rd_addr_b,
  output logic [HALF_AW-1:0] coef_addr,
  output logic               acc_en,
  output logic               acc_first,
  output logic               centre,
  output logic               out_fire,
  output logic               busy,
  output logic [AW-1:0]      wr_ptr,
  output logic [TAP_W-1:0]   taps
);
  fold_state_e        st_q, st_d;
  logic [HALF_AW-1:0] k_q, k_d;
  logic [AW-1:0]      ptr_q, head_q;
  logic [TAP_W-1:0]   taps_q, taps_clamp;
  logic [TAP_W-1:0]   half_m, last_w, far_off;
  logic [HALF_AW-1:0] last_k;
  logic               accept, last_pair, odd_len;

  // tap count clamp applied at acceptance
  always_comb begin
    if (tap_num < TAP_W'(2)) begin
      taps_clamp = TAP_W'(2);
    end else if (tap_num > TAP_W'(MAX_TAPS)) begin
      taps_clamp = TAP_W'(MAX_TAPS);
    end else begin
      taps_clamp = tap_num;
    end
  end

  always_comb begin
    half_m    = (taps_q + TAP_W'(1)) >> 1;
    last_w    = half_m - TAP_W'(1);
    last_k    = last_w[HALF_AW-1:0];
    odd_len   = taps_q[0];
    last_pair = (k_q == last_k);
    far_off   = taps_q - TAP_W'(1) - TAP_W'(k_q);
  end

  assign accept = (st_q == ST_IDLE) && in_valid && !load;

  // next-state logic
  always_comb begin
    st_d = st_q;
    k_d  = k_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d = ST_RUN;
          k_d  = '0;
        end
      end
      ST_RUN: begin
        if (last_pair) begin
          st_d = ST_DONE;
        end else begin
          k_d = k_q + HALF_AW'(1);
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (load) begin
      st_d = ST_IDLE;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      k_q  <= '0;
    end else begin
      st_q <= st_d;
      k_q  <= k_d;
    end
  end

  // pointer and tap registers, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      head_q <= '0;
      taps_q <= TAP_W'(2);
    end else if (accept) begin
      ptr_q  <= ptr_q + AW'(1);
      head_q <= ptr_q;
      taps_q <= taps_clamp;
    end
  end

  assign wr_en     = accept;
  assign wr_addr   = ptr_q;
  assign rd_addr_a = head_q - AW'(k_q);
  assign rd_addr_b = head_q - far_off[AW-1:0];
  assign coef_addr = k_q;
  assign acc_en    = (st_q == ST_RUN);
  assign acc_first = (k_q == '0);
  assign centre    = odd_len && last_pair;
  assign out_fire  = (st_q == ST_DONE) && !load;
  assign busy      = (st_q != ST_IDLE);
  assign wr_ptr    = ptr_q;
  assign taps      = taps_q;
endmodule

// File: rtl/fold_mac.sv
// Pre-adder, single multiplier, accumulator, round/saturate, output register.
module fold_mac #(
  parameter int DATA_W   = 8,
  parameter int COEF_W   = 8,
  parameter int FRAC_W   = 7,
  parameter int MAX_TAPS = 16,
  localparam int PRE_W   = DATA_W + 1,
  localparam int PROD_W  = PRE_W + COEF_W,
  localparam int ACC_W   = PROD_W + $clog2(MAX_TAPS / 2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_first,
  input  logic              centre,
  input  logic              out_fire,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic [COEF_W-1:0] coef,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int RND_HALF = 1 << (FRAC_W - 1);
  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = ~SAT_HI;

  logic [PRE_W-1:0]   pre_a, pre_b, pre_sum;
  logic [PROD_W-1:0]  pre_x, coef_x, prod;
  logic [ACC_W-1:0]   acc_q, acc_d, acc_base;
  logic [ACC_W:0]     rnd;
  logic signed [ACC_W:0] shf;
  logic [DATA_W-1:0]  sat_val;
  logic [DATA_W-1:0]  out_q;
  logic               valid_q;

  // pre-adder: full-width pair sum, centre tap uses one operand
  always_comb begin
    pre_a   = {smp_a[DATA_W-1], smp_a};
    pre_b   = centre ? '0 : {smp_b[DATA_W-1], smp_b};
    pre_sum = pre_a + pre_b;
  end

  // single multiplier and accumulate
  always_comb begin
    pre_x    = {{COEF_W{pre_sum[PRE_W-1]}}, pre_sum};
    coef_x   = {{PRE_W{coef[COEF_W-1]}}, coef};
    prod     = PROD_W'($signed(pre_x) * $signed(coef_x));
    acc_base = acc_first ? '0 : acc_q;
    acc_d    = acc_base + {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  end

  // round half up, then clamp to the sample range
  always_comb begin
    rnd = {acc_q[ACC_W-1], acc_q} + (ACC_W+1)'(RND_HALF);
    shf = $signed(rnd) >>> FRAC_W;
    if (shf > SAT_HI) begin
      sat_val = {1'b0, {(DATA_W - 1){1'b1}}};
    end else if (shf < SAT_LO) begin
      sat_val = {1'b1, {(DATA_W - 1){1'b0}}};
    end else begin
      sat_val = shf[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= out_fire;
      if (out_fire) begin
        out_q <= sat_val;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = out_q;
endmodule

// File: rtl/folded_fir.sv
module folded_fir #(
  parameter int DATA_W    = 8,
  parameter int COEF_W    = 8,
  parameter int FRAC_W    = 7,
  parameter int MAX_TAPS  = 16,
  localparam int AW       = $clog2(MAX_TAPS),
  localparam int HALF     = MAX_TAPS / 2,
  localparam int HALF_AW  = $clog2(HALF),
  localparam int TAP_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               coef_we,
  input  logic [HALF_AW-1:0] coef_addr,
  input  logic [COEF_W-1:0]  coef_data,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [TAP_W-1:0]   tap_num,
  output logic               out_valid,
  output logic [DATA_W-1:0]  out_data
);
  logic               rst_sync_n;
  logic               wr_en, acc_en, acc_first, centre, out_fire, busy;
  logic [AW-1:0]      wr_addr, rd_addr_a, rd_addr_b, wr_ptr;
  logic [HALF_AW-1:0] coef_rd_addr;
  logic [TAP_W-1:0]   taps_q;
  logic [DATA_W-1:0]  smp_a, smp_b;
  logic [COEF_W-1:0]  coef_rd;

  fold_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fold_ctrl #(.MAX_TAPS(MAX_TAPS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (coef_we),
    .in_valid  (in_valid),
    .tap_num   (tap_num),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .coef_addr (coef_rd_addr),
    .acc_en    (acc_en),
    .acc_first (acc_first),
    .centre    (centre),
    .out_fire  (out_fire),
    .busy      (busy),
    .wr_ptr    (wr_ptr),
    .taps      (taps_q)
  );

  fold_hist_ram #(.DATA_W(DATA_W), .DEPTH(MAX_TAPS)) u_hist (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (coef_we),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (in_data),
    .raddr_a (rd_addr_a),
    .raddr_b (rd_addr_b),
    .rdata_a (smp_a),
    .rdata_b (smp_b)
  );

  fold_coef_ram #(.COEF_W(COEF_W), .DEPTH(HALF)) u_coef (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_data),
    .raddr (coef_rd_addr),
    .rdata (coef_rd)
  );

  fold_mac #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .FRAC_W   (FRAC_W),
    .MAX_TAPS (MAX_TAPS)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .acc_en    (acc_en),
    .acc_first (acc_first),
    .centre    (centre),
    .out_fire  (out_fire),
    .smp_a     (smp_a),
    .smp_b     (smp_b),
    .coef      (coef_rd),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/folded_fir_chk.sv
module folded_fir_chk #(
  parameter int DATA_W   = 8,
  parameter int MAX_TAPS = 16,
  localparam int AW      = $clog2(MAX_TAPS),
  localparam int TAP_W   = $clog2(MAX_TAPS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              coef_we,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              busy,
  input logic [AW-1:0]     wr_ptr,
  input logic [TAP_W-1:0]  taps_q
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R5

  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && !coef_we) |=> busy); // R5

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> $stable(wr_ptr)); // R6

  AST_TAPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (taps_q >= TAP_W'(2) && taps_q <= TAP_W'(MAX_TAPS))); // R7

  AST_LOAD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> (!out_valid && !busy)); // R9
endmodule

bind folded_fir folded_fir_chk #(
  .DATA_W   (DATA_W),
  .MAX_TAPS (MAX_TAPS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .coef_we   (coef_we),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .busy      (busy),
  .wr_ptr    (wr_ptr),
  .taps_q    (taps_q)
);

// File: tb/folded_fir_bench.sv
`timescale 1ns/1ps
module folded_fir_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       coef_we;
  logic [2:0] coef_addr;
  logic [7:0] coef_data;
  logic       in_valid;
  logic [7:0] in_data;
  logic [4:0] tap_num;
  logic       out_valid;
  logic [7:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int hst [16];
  int cf  [8];

  always #2 clk = ~clk;

  folded_fir u_folded_fir (
    .clk       (clk),
    .rst_n     (rst_n),
    .coef_we   (coef_we),
    .coef_addr (coef_addr),
    .coef_data (coef_data),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .tap_num   (tap_num),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp_m(input int m);
    if (m < 2) return 2;
    if (m > 16) return 16;
    return m;
  endfunction

  function automatic int model(input int m_in);
    int m = clamp_m(m_in);
    int h = (m + 1) / 2;
    longint y = 0;
    for (int k = 0; k < h; k++) begin
      int s;
      if ((m % 2) == 1 && k == h - 1) s = hst[k];
      else s = hst[k] + hst[m - 1 - k];
      y += longint'(cf[k]) * longint'(s);
    end
    y = (y + 64) >>> 7;
    if (y > 127) return 127;
    if (y < -128) return -128;
    return int'(y);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; coef_we = 0; coef_addr = 0; coef_data = 0;
    in_valid = 0; in_data = 0; tap_num = 5'd2;
    for (int i = 0; i < 16; i++) hst[i] = 0;
    for (int i = 0; i < 8; i++) cf[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_coef(input int addr, input int val);
    @(negedge clk);
    coef_we = 1; coef_addr = addr[2:0]; coef_data = val[7:0];
    @(negedge clk);
    coef_we = 0;
    cf[addr] = val;
    for (int i = 0; i < 16; i++) hst[i] = 0;
  endtask

  // push one sample, optionally strobe an intruding sample while busy
  task automatic push_check(input int x, input int m, input string req,
                            input bit intr = 0, input int intr_val = 0);
    int exp_v, lat, h;
    bit seen;
    @(negedge clk);
    in_valid = 1; in_data = x[7:0]; tap_num = m[4:0];
    for (int i = 15; i > 0; i--) hst[i] = hst[i-1];
    hst[0] = x;
    exp_v = model(m);
    h = (clamp_m(m) + 1) / 2;
    @(negedge clk);
    in_valid = 0;
    lat = 1; seen = 0;
    while (!seen && lat < 40) begin
      if (out_valid) seen = 1;
      else begin
        @(negedge clk);
        lat++;
        if (intr && lat == 2) begin in_valid = 1; in_data = intr_val[7:0]; end
        if (intr && lat == 3) in_valid = 0;
      end
    end
    chk(seen && lat == h + 2, "R5 latency", lat, h + 2);
    chk(int'($signed(out_data)) == exp_v, req, int'($signed(out_data)), exp_v);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 pulse width", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(out_data == 8'd0, "R1 data after reset", int'(out_data), 0);
    push_check(100, 4, "R1 zero coefficients");
  endtask

  task automatic t_even();
    write_coef(0, 10); write_coef(1, -20); write_coef(2, 30); write_coef(3, 40);
    push_check(50, 8, "R2 even M=8 a");
    push_check(-70, 8, "R2 even M=8 b");
    push_check(33, 8, "R2 even M=8 c");
    push_check(120, 6, "R2 even M=6");
    push_check(-5, 2, "R2 even M=2");
  endtask

  task automatic t_odd();
    write_coef(0, 12); write_coef(1, -25); write_coef(2, 64); write_coef(3, 100);
    push_check(90, 7, "R3 odd M=7 a");
    push_check(-60, 7, "R3 odd M=7 b");
    push_check(77, 7, "R3 odd M=7 c");
    push_check(41, 5, "R3 odd M=5");
    push_check(-99, 3, "R3 odd M=3");
  endtask

  task automatic t_coef_index();
    for (int k = 0; k < 8; k++) write_coef(k, 8 * k + 3);
    push_check(127, 16, "R8 impulse k0");
    for (int j = 1; j < 10; j++) push_check(0, 16, "R8 impulse tail");
  endtask

  task automatic t_sat();
    write_coef(0, 64);
    for (int k = 1; k < 8; k++) write_coef(k, 0);
    push_check(-128, 2, "R4 pre-add first");
    push_check(-128, 2, "R4 pre-add -256");
    push_check(127, 2, "R4 pre-add mixed");
    push_check(127, 2, "R4 pre-add +254");
    for (int k = 0; k < 8; k++) write_coef(k, 127);
    for (int j = 0; j < 16; j++) push_check(127, 16, "R4 saturate high");
    for (int j = 0; j < 16; j++) push_check(-128, 16, "R4 saturate low");
  endtask

  task automatic t_busy_drop();
    write_coef(0, 50); write_coef(1, 30); write_coef(2, -40); write_coef(3, 20);
    write_coef(4, 0); write_coef(5, 0); write_coef(6, 0); write_coef(7, 0);
    push_check(60, 8, "R6 intruded output", 1, 111);
    push_check(-20, 8, "R6 history without dropped", 1, -77);
    push_check(15, 1, "R6 short run intruded", 1, 99);
    push_check(25, 8, "R6 follow-up");
  endtask

  task automatic t_clamp();
    write_coef(0, 40); write_coef(1, 60); write_coef(7, 90);
    for (int j = 0; j < 16; j++) push_check(j * 7 - 50, 16, "R7 fill");
    push_check(20, 0, "R7 tap 0 as 2");
    push_check(-30, 25, "R7 tap 25 as 16");
    push_check(44, 31, "R7 tap 31 as 16");
    push_check(-9, 1, "R7 tap 1 as 2");
  endtask

  task automatic t_load_abort();
    int hits;
    write_coef(0, 70); write_coef(1, 15);
    push_check(80, 16, "R9 before abort");
    @(negedge clk);
    in_valid = 1; in_data = 8'd90; tap_num = 5'd16;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    coef_we = 1; coef_addr = 3'd1; coef_data = 8'd5;
    @(negedge clk);
    coef_we = 0;
    cf[1] = 5;
    for (int i = 0; i < 16; i++) hst[i] = 0;
    hits = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (out_valid) hits++;
    end
    chk(hits == 0, "R9 no output after abort", hits, 0);
    push_check(50, 16, "R9 history cleared");
    push_check(-50, 16, "R9 second after clear");
  endtask

  task automatic t_wrap();
    write_coef(0, 9); write_coef(1, -14); write_coef(2, 21); write_coef(3, 33);
    write_coef(4, -8); write_coef(5, 17); write_coef(6, 26); write_coef(7, -3);
    for (int j = 0; j < 40; j++)
      push_check(((j * 37) % 200) - 100, (j % 3 == 0) ? 15 : 16, "R10 wrap");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_even();
    t_odd();
    t_coef_index();
    t_sat();
    t_busy_drop();
    t_clamp();
    t_load_abort();
    t_wrap();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule